// File: doc/BRIEF.md
# SDRAM Burst Read Output Pipeline

This block models the device-side read data path of a four-bank synchronous DRAM. Each clock it takes one decoded command (no-op, read, write or precharge) with a bank and column address, plus a per-cycle output mask bit. It returns the data word on the output pins together with an output-enable that tells whether the pins are driven or left at high impedance. A small internal register file stands in for the storage array, and a write places one word into it.

A read starts a four-word burst. The column address steps upward inside its aligned group of four and wraps around within that group. Each issued word travels through a latency line whose length is the programmed CAS latency (2 or 3). A separate line, fixed at two clocks, carries the mask. A new read cuts off a running burst on any cycle, and its words follow the old ones with no gap. A precharge to the bank being read, a precharge to all banks, or a write stops the burst from issuing more words. Words already inside the latency line still come out.

Top module: `sdram_rd_pipe`

## Requirements
- R1: Every edge is counted, and the edge that samples a READ is edge 0. Word 0 of the burst drives the pins from edge CL on, where CL is 2 or 3.
- R2: A READ with no interruption drives four words on consecutive clocks. The low two column bits count up modulo 4 from the given column, and the upper column bits stay fixed.
- R3: A READ sampled while a burst is issuing ends that burst. The old words issued at earlier edges still appear. The new burst's word 0 appears on the clock right after the last old word, with the same CL.
- R4: A precharge (cmd=2'b11) stops a running burst from issuing further words when all_banks=1 or when its bank equals the burst's bank. Words issued at earlier edges are still driven. A precharge to any other bank has no effect on the burst.
- R5: A WRITE (cmd=2'b10) stores wdata at the given bank and column, and a later READ returns that value. A WRITE also ends a running burst in the same way as R4.
- R6: The dqm value sampled at edge k forces dq_oe low for the word that would drive from edge k+2, regardless of CL.
- R7: On every cycle that carries no unmasked read word, dq_oe is 0 and dq_out is all zeros.
- R8: mode_set loads CL=3 when cl_sel=1 and CL=2 when cl_sel=0. It is ignored while a burst is issuing or any word is still in the latency line.
- R9: During reset and right after it, dq_oe is 0 and dq_out is 0, and CL is 3. Command codes: 2'b00 no-op, 2'b01 READ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 2 | Decoded command: 0 no-op, 1 read, 2 write, 3 precharge |
| bank | input | BANK_W | Bank address |
| col | input | COL_W | Column address |
| all_banks | input | 1 | With precharge: apply to every bank |
| wdata | input | DATA_W | Write data |
| dqm | input | 1 | Output mask, applied two clocks later |
| mode_set | input | 1 | Load the CAS latency from cl_sel |
| cl_sel | input | 1 | 1 selects CL=3, 0 selects CL=2 |
| dq_out | output | DATA_W | Read data, zero when not driven |
| dq_oe | output | 1 | Output enable for the data pins |

## Verification
On every cycle, the checker confirms four things: the two-clock mask blanks the output, the first word arrives at the right clock for both latencies, the output stays off once no read has been seen long enough for any burst to drain, and precharge-all leaves nothing past the committed words. It also holds the latency register steady while work is in flight. The values of the data words, the wrap order inside the aligned group, the exact number of old words that survive a read, precharge or write cut-off, and whether a mode change was ignored can only be shown by the bench's scenarios against its shadow of the storage.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;
   typedef enum logic [1:0] {
      CMD_NOP   = 2'b00,
      CMD_READ  = 2'b01,
      CMD_WRITE = 2'b10,
      CMD_PRE   = 2'b11
   } sdr_cmd_e;

   localparam int unsigned MAX_CL = 3;
   localparam int unsigned MIN_CL = 2;
endpackage

// File: rtl/sdram_rd_dline.sv
module sdram_rd_dline #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [W-1:0]             din,
   output logic [DEPTH-1:0][W-1:0]  taps
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("sdram_rd_dline: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
         if (!rst_n) taps <= '0;
         else        taps <= din;
      end
   end else begin : g_shift
      always_ff @(posedge clk) begin
         if (!rst_n) taps <= '0;
         else        taps <= {taps[DEPTH-2:0], din};
      end
   end
endmodule

// File: rtl/sdram_rd_array.sv
module sdram_rd_array #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 6
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned WORDS = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/sdram_rd_burst.sv
module sdram_rd_burst
   import sdram_rd_pkg::*;
#(
   parameter int unsigned BANK_W    = 2,
   parameter int unsigned COL_W     = 4,
   parameter int unsigned BURST_LEN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sdr_cmd_e          cmd,
   input  logic [BANK_W-1:0] bank,
   input  logic [COL_W-1:0]  col,
   input  logic              all_banks,
   output logic              issue_v,
   output logic [BANK_W-1:0] issue_bank,
   output logic [COL_W-1:0]  issue_col,
   output logic              live
);
   localparam int unsigned BL_W = $clog2(BURST_LEN);

   logic [BANK_W-1:0] b_bank;
   logic [COL_W-1:0]  b_col;
   logic [BL_W-1:0]   b_cnt;
   logic              stop;
   logic [BL_W-1:0]   low_sum;

   assign stop = (cmd == CMD_WRITE) ||
                 ((cmd == CMD_PRE) && (all_banks || (bank == b_bank)));
   assign low_sum = b_col[BL_W-1:0] + b_cnt;

   always_comb begin
      issue_v    = 1'b0;
      issue_bank = b_bank;
      issue_col  = b_col;
      if (cmd == CMD_READ) begin
         issue_v    = 1'b1;
         issue_bank = bank;
         issue_col  = col;
      end else if (live && !stop) begin
         issue_v    = 1'b1;
         issue_col  = {b_col[COL_W-1:BL_W], low_sum};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live   <= 1'b0;
         b_bank <= '0;
         b_col  <= '0;
         b_cnt  <= '0;
      end else if (cmd == CMD_READ) begin
         live   <= 1'b1;
         b_bank <= bank;
         b_col  <= col;
         b_cnt  <= BL_W'(1);
      end else if (live) begin
         if (stop || (b_cnt == BL_W'(BURST_LEN - 1))) live <= 1'b0;
         b_cnt <= b_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe
   import sdram_rd_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned BANK_W    = 2,
   parameter int unsigned COL_W     = 4,
   parameter int unsigned BURST_LEN = 4,
   parameter int unsigned DQM_LAT   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cmd,
   input  logic [BANK_W-1:0] bank,
   input  logic [COL_W-1:0]  col,
   input  logic              all_banks,
   input  logic [DATA_W-1:0] wdata,
   input  logic              dqm,
   input  logic              mode_set,
   input  logic              cl_sel,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe
);
   localparam int unsigned ADDR_W  = BANK_W + COL_W;
   localparam int unsigned P_DEPTH = MAX_CL + 1;
   localparam int unsigned P_W     = DATA_W + 1;
   localparam int unsigned M_DEPTH = DQM_LAT + 1;

   if (BURST_LEN < 2 || (BURST_LEN & (BURST_LEN - 1)) != 0) begin : g_bad_bl
      $error("sdram_rd_pipe: BURST_LEN must be a power of two of at least 2");
   end
   if (BURST_LEN > (1 << COL_W)) begin : g_bad_col
      $error("sdram_rd_pipe: BURST_LEN exceeds the column space");
   end
   if (DATA_W < 1 || DQM_LAT < 1) begin : g_bad_w
      $error("sdram_rd_pipe: DATA_W and DQM_LAT must be positive");
   end

   sdr_cmd_e          cmd_e;
   logic              issue_v;
   logic [BANK_W-1:0] issue_bank;
   logic [COL_W-1:0]  issue_col;
   logic              burst_live;
   logic [DATA_W-1:0] rd_data;
   logic [P_DEPTH-1:0][P_W-1:0] pipe_taps;
   logic [M_DEPTH-1:0][0:0]     mask_taps;
   logic [1:0]        cl_q;
   logic              busy;
   logic [P_W-1:0]    sel;

   assign cmd_e = sdr_cmd_e'(cmd);

   sdram_rd_burst #(
      .BANK_W(BANK_W), .COL_W(COL_W), .BURST_LEN(BURST_LEN)
   ) burst_i (
      .clk(clk), .rst_n(rst_n), .cmd(cmd_e), .bank(bank), .col(col),
      .all_banks(all_banks), .issue_v(issue_v), .issue_bank(issue_bank),
      .issue_col(issue_col), .live(burst_live)
   );

   sdram_rd_array #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W)
   ) array_i (
      .clk(clk), .we(cmd_e == CMD_WRITE), .waddr({bank, col}), .wdata(wdata),
      .raddr({issue_bank, issue_col}), .rdata(rd_data)
   );

   sdram_rd_dline #(
      .W(P_W), .DEPTH(P_DEPTH)
   ) data_line_i (
      .clk(clk), .rst_n(rst_n), .din({issue_v, rd_data}), .taps(pipe_taps)
   );

   sdram_rd_dline #(
      .W(1), .DEPTH(M_DEPTH)
   ) mask_line_i (
      .clk(clk), .rst_n(rst_n), .din(dqm), .taps(mask_taps)
   );

   always_comb begin
      busy = burst_live;
      for (int i = 0; i < int'(MAX_CL); i++) begin
         busy = busy | pipe_taps[i][DATA_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                cl_q <= 2'(MAX_CL);
      else if (mode_set && !busy) cl_q <= cl_sel ? 2'(MAX_CL) : 2'(MIN_CL);
   end

   assign sel    = pipe_taps[cl_q];
   assign dq_oe  = sel[DATA_W] & ~mask_taps[DQM_LAT][0];
   assign dq_out = dq_oe ? sel[DATA_W-1:0] : '0;
endmodule

// File: rtl/sdram_rd_pipe_chk.sv
module sdram_rd_pipe_chk
   import sdram_rd_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        cmd,
   input logic              all_banks,
   input logic              dqm,
   input logic              busy,
   input logic [1:0]        cl_q,
   input logic              dq_oe,
   input logic [DATA_W-1:0] dq_out
);
   logic [3:0] cyc;

   always_ff @(posedge clk) begin
      if (!rst_n)             cyc <= '0;
      else if (cyc != 4'hF)   cyc <= cyc + 1'b1;
   end

   // R6: mask sampled three checker samples back blanks the output
   p_dqm_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc > 4'd3 && $past(dqm, 3)) |-> !dq_oe);

   // R1: first word at CL=2
   p_first_word_cl2_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc > 4'd4 && cl_q == 2'd2 && $past(cl_q, 3) == 2'd2 &&
       $past(cmd, 3) == CMD_READ && !$past(dqm, 3)) |-> dq_oe);

   // R1: first word at CL=3
   p_first_word_cl3_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc > 4'd5 && cl_q == 2'd3 && $past(cl_q, 4) == 2'd3 &&
       $past(cmd, 4) == CMD_READ && !$past(dqm, 3)) |-> dq_oe);

   // R7: output off once any burst has drained
   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc > 4'd8 &&
       $past(cmd, 1) != CMD_READ && $past(cmd, 2) != CMD_READ &&
       $past(cmd, 3) != CMD_READ && $past(cmd, 4) != CMD_READ &&
       $past(cmd, 5) != CMD_READ && $past(cmd, 6) != CMD_READ &&
       $past(cmd, 7) != CMD_READ) |-> (!dq_oe && dq_out == '0));

   // R4: precharge-all leaves nothing past the committed words (CL=3)
   p_prech_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc > 4'd6 && cl_q == 2'd3 && $past(cl_q, 4) == 2'd3 &&
       $past(cmd, 4) == CMD_PRE && $past(all_banks, 4) &&
       $past(cmd, 3) != CMD_READ && $past(cmd, 2) != CMD_READ &&
       $past(cmd, 1) != CMD_READ) |-> !dq_oe);

   // R8: latency register holds while work is in flight
   p_cl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(cl_q));

   // R8: latency register only ever holds a legal value
   p_cl_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cl_q == 2'd2 || cl_q == 2'd3));
endmodule

bind sdram_rd_pipe sdram_rd_pipe_chk #(.DATA_W(DATA_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .cmd(cmd), .all_banks(all_banks), .dqm(dqm),
   .busy(busy), .cl_q(cl_q), .dq_oe(dq_oe), .dq_out(dq_out)
);

// File: tb/sdram_rd_pipe_tb.sv
module sdram_rd_pipe_tb_top;
   import sdram_rd_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cmd = 2'b00;
   logic [1:0]  bank = '0;
   logic [3:0]  col = '0;
   logic        all_banks = 1'b0;
   logic [15:0] wdata = '0;
   logic        dqm = 1'b0;
   logic        mode_set = 1'b0;
   logic        cl_sel = 1'b0;
   logic [15:0] dq_out;
   logic        dq_oe;

   always #2 clk = ~clk;

   sdram_rd_pipe dut_i (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .col(col),
      .all_banks(all_banks), .wdata(wdata), .dqm(dqm), .mode_set(mode_set),
      .cl_sel(cl_sel), .dq_out(dq_out), .dq_oe(dq_oe)
   );

   typedef struct {
      int          cyc;
      logic [15:0] data;
      string       tag;
   } exp_t;

   exp_t        q[$];
   logic [15:0] mem_m [64];
   bit          dqm_hist [4096];
   int          ecnt = 0;
   int          cl = 3;
   int          n_run = 0;
   int          n_fail = 0;
   bit          mon_en = 1'b0;
   bit          done = 1'b0;

   always @(posedge clk) begin
      if (rst_n) ecnt <= ecnt + 1;
      else       ecnt <= 0;
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s at cycle %0d: actual %h expected %h",
                  tag, what, ecnt, act, exp);
      end
   endtask

   // monitor: pops expected words as their cycle arrives
   always @(negedge clk) begin
      if (mon_en && !done) begin
         bit   msk;
         exp_t it;
         msk = (ecnt >= 2) ? dqm_hist[ecnt-2] : 1'b0;
         if (q.size() > 0 && q[0].cyc < ecnt) begin
            it = q.pop_front();
            chk(1'b0, it.tag, "word missed", 16'(ecnt), 16'(it.cyc));
         end
         if (q.size() > 0 && q[0].cyc == ecnt) begin
            it = q.pop_front();
            chk(dq_oe == !msk, msk ? "R6" : it.tag, "oe", 16'(dq_oe), 16'(!msk));
            chk(dq_out == (msk ? 16'h0 : it.data), it.tag, "data",
                dq_out, msk ? 16'h0 : it.data);
         end else begin
            chk(!dq_oe && dq_out == 16'h0, "R7", "idle pins",
                {dq_oe, dq_out[14:0]}, 16'h0);
         end
      end
   end

   task automatic drive(input logic [1:0] c, input int b, input int cc,
                        input logic ab, input logic dq, input logic [15:0] wd,
                        input logic ms, input logic cs);
      @(negedge clk);
      cmd = c; bank = 2'(b); col = 4'(cc); all_banks = ab; dqm = dq;
      wdata = wd; mode_set = ms; cl_sel = cs;
      dqm_hist[ecnt+1] = dq;
   endtask

   task automatic nop(input int n, input logic dq = 1'b0);
      for (int i = 0; i < n; i++) drive(CMD_NOP, 0, 0, 1'b0, dq, 16'h0, 1'b0, 1'b0);
   endtask

   task automatic rd(input int b, input int c, input int n, input string tag);
      @(negedge clk);
      for (int k = 0; k < n; k++) begin
         exp_t it;
         it.cyc  = ecnt + 1 + cl + k;
         it.data = mem_m[b*16 + ((c & 12) | ((c + k) & 3))];
         it.tag  = tag;
         q.push_back(it);
      end
      cmd = CMD_READ; bank = 2'(b); col = 4'(c); all_banks = 1'b0; dqm = 1'b0;
      mode_set = 1'b0;
      dqm_hist[ecnt+1] = 1'b0;
   endtask

   task automatic wr(input int b, input int c, input logic [15:0] v);
      drive(CMD_WRITE, b, c, 1'b0, 1'b0, v, 1'b0, 1'b0);
      mem_m[b*16 + c] = v;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!dq_oe && dq_out == 16'h0, "R9", "reset pins", {dq_oe, dq_out[14:0]}, 16'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!dq_oe && dq_out == 16'h0, "R9", "after reset", {dq_oe, dq_out[14:0]}, 16'h0);
      mon_en = 1'b1;

      for (int b = 0; b < 4; b++)
         for (int c = 0; c < 16; c++)
            wr(b, c, {4'hA, 2'(b), 2'b01, 4'(c), ~4'(c)});
      nop(2);

      // R2 wrap, R9 reset latency of 3 (R1)
      rd(0, 1, 4, "R2"); nop(8);
      rd(2, 14, 4, "R1"); nop(8);

      // R8: switch to CL=2 while idle
      drive(CMD_NOP, 0, 0, 1'b0, 1'b0, 16'h0, 1'b1, 1'b0); cl = 2; nop(2);
      rd(1, 6, 4, "R1"); nop(8);

      // R3: read cut by read, other bank and same bank
      rd(2, 0, 1, "R3"); rd(3, 9, 4, "R3"); nop(8);
      rd(0, 4, 2, "R3"); nop(1); rd(0, 8, 4, "R3"); nop(8);

      // R4: precharge same bank, other bank, all banks
      rd(1, 0, 2, "R4"); nop(1); drive(CMD_PRE, 1, 0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0); nop(8);
      rd(1, 4, 4, "R4"); drive(CMD_PRE, 2, 0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0); nop(8);
      rd(2, 12, 1, "R4"); drive(CMD_PRE, 3, 0, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0); nop(8);

      // R5: write ends burst, new value read back
      rd(3, 0, 1, "R5"); wr(0, 15, 16'h5A5A); nop(8);
      rd(0, 12, 4, "R5"); nop(8);

      // R6: mask mid-burst, and mask on an idle cycle
      rd(0, 0, 4, "R6"); nop(1, 1'b1); nop(8);
      nop(1, 1'b1); nop(4);

      // R8: mode_set during a burst is ignored
      rd(1, 8, 4, "R8");
      drive(CMD_NOP, 0, 0, 1'b0, 1'b0, 16'h0, 1'b1, 1'b1); nop(8);
      rd(2, 3, 4, "R8"); nop(8);
      drive(CMD_NOP, 0, 0, 1'b0, 1'b0, 16'h0, 1'b1, 1'b1); cl = 3; nop(2);
      rd(3, 5, 4, "R8"); nop(1, 1'b1); nop(8);
      rd(0, 2, 1, "R3"); rd(1, 10, 4, "R3"); nop(10);

      chk(q.size() == 0, "R3", "words left in scoreboard", 16'(q.size()), 16'h0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired: actual running expected finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule